// File: doc/BRIEF.md
# Byte-Wide SPI Master with Read-Launched Transfers

This block is an SPI master controlled through a small byte-wide register port. Software sets a divider and an enable, picks master operation, and chooses one of the four clock polarity and phase combinations. Writing a byte to the data register shifts that byte out over eight serial clock pulses, most significant bit first. A busy flag shows that a transfer is running. Chip select stays with general-purpose pins outside this block.

Receiving works as a one-byte pipeline. With the read-mode bit set, each read of the data register returns the byte captured by the previous transfer and starts the next transfer in the same access. The first read after a command therefore returns a stale byte. Clearing read mode before the last read collects the final byte without starting another transfer. A control bit holds the serial output low during reads. A further bit turns the output pin into a shared three-wire data line: when the output is disabled, the pin's driver is released and the input is sampled from that pin.

Top module: `spi_rdpipe_master`

## Requirements
- R1: After reset all registers read 0, busy (control bit 6) is 0, the serial clock is low, the data output is low and its output enable is high.
- R2: When the function is enabled and master mode is selected, a write to the data register (address 3) while idle starts a transfer. Busy reads 1 from the next cycle and stays 1 for exactly 16*(DIV+1) system cycles, where DIV is speed register (address 0) bits 6:0.
- R3: The serial clock idles at CPOL (mode register, address 2, bit 0). Each transfer makes 8 pulses and ends at the CPOL level.
- R4: Data goes out MSB first. With CPHA (mode bit 1) = 0 the output changes on second edges and is stable on first edges. With CPHA = 1 it changes on first edges and is stable on second edges. The slave receives the written byte in all four modes.
- R5: The byte sampled on the input line (first edges for CPHA=0, second edges for CPHA=1) is returned by the next data-register read, in all four modes.
- R6: With read mode (control bit 3) set, an idle data-register read returns the byte from the previous transfer and starts a new transfer that shifts out the last byte written.
- R7: With read mode clear, a data-register read returns the held byte and starts no transfer.
- R8: While busy, writes and reads of the data register start nothing, and a write while busy does not change the byte to be shifted out.
- R9: When output disable (control bit 2) is set, the serial data output stays low.
- R10: With share mode (control bit 5) and output disable both set, the output enable is low and the input comes from the shared pin. Otherwise the output enable is high and the input comes from the dedicated input pin.
- R11: No transfer starts while the enable bit (speed bit 7) or master mode (control bit 1) is clear. A write to the speed register replaces both of its fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 speed, 1 control, 2 mode, 3 data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, valid in the strobe cycle |
| spi_sck | output | 1 | Serial clock |
| spi_dout | output | 1 | Serial data output |
| spi_dout_en | output | 1 | Output enable for the serial data pin |
| spi_din | input | 1 | Dedicated serial data input |
| spi_dio_in | input | 1 | Input path of the shared three-wire data pin |

## Verification
The hardest case to reach is the read pipeline, where each read returns one byte and launches the capture of the next. To reach it, the stimulus issues a command write, switches on read mode and output disable, and performs a chain of reads. A model slave feeds a new byte for each transfer, and the scoreboard expects each read to return the byte from one transfer earlier. The stimulus also places a data write and a data read inside a running transfer. It then checks that the shifted-out byte and the transfer length are unchanged. For the shared-pin choice, the two input pins are driven with opposite data, so a wrong input selection gives an inverted byte.

// File: rtl/spirp_pkg.sv
package spirp_pkg;
  localparam logic [1:0] ADDR_SPEED = 2'd0;
  localparam logic [1:0] ADDR_CTRL  = 2'd1;
  localparam logic [1:0] ADDR_MODE  = 2'd2;
  localparam logic [1:0] ADDR_DATA  = 2'd3;

  localparam int CTL_MASTER = 1;
  localparam int CTL_NODOUT = 2;
  localparam int CTL_RDMODE = 3;
  localparam int CTL_SHARE  = 5;
  localparam int CTL_BUSY   = 6;

  typedef struct packed {
    logic enable;
    logic master;
    logic no_dout;
    logic rd_mode;
    logic share;
    logic cpol;
    logic cpha;
  } cfg_t;

  // system cycles that one transfer keeps busy high
  function automatic int unsigned xfer_cycles(input int unsigned div_val,
                                              input int unsigned data_w);
    return 2 * data_w * (div_val + 1);
  endfunction

  // sampling edges: first edges (even index) for cpha=0, second for cpha=1
  function automatic logic is_sample_edge(input logic idx_lsb, input logic cpha);
    return idx_lsb == cpha;
  endfunction

  // launch edges: the other edges, minus the very first one when cpha=1
  function automatic logic is_launch_edge(input logic idx_lsb, input logic idx_first,
                                          input logic cpha);
    return (idx_lsb != cpha) && !(cpha && idx_first);
  endfunction
endpackage

// File: rtl/spirp_regs.sv
module spirp_regs
  import spirp_pkg::*;
#(
  parameter int DIV_W = 7,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       addr,
  input  logic             wr,
  input  logic             rd,
  input  logic [DW-1:0]    wdata,
  input  logic             busy,
  input  logic [DW-1:0]    rx_hold,
  output logic [DW-1:0]    rdata,
  output cfg_t             cfg,
  output logic [DIV_W-1:0] div,
  output logic             start,
  output logic [DW-1:0]    tx_load,
  output logic [DW-1:0]    tx_hold
);
  logic ready, data_sel, start_wr, start_rd;

  assign ready    = cfg.enable && cfg.master && !busy;
  assign data_sel = (addr == ADDR_DATA);
  assign start_wr = wr && data_sel && ready;
  assign start_rd = rd && data_sel && ready && cfg.rd_mode;
  assign start    = start_wr || start_rd;
  assign tx_load  = start_wr ? wdata : tx_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg     <= '0;
      div     <= '0;
      tx_hold <= '0;
    end else begin
      if (wr && addr == ADDR_SPEED) begin
        cfg.enable <= wdata[DIV_W];
        div        <= wdata[DIV_W-1:0];
      end
      if (wr && addr == ADDR_CTRL) begin
        cfg.master  <= wdata[CTL_MASTER];
        cfg.no_dout <= wdata[CTL_NODOUT];
        cfg.rd_mode <= wdata[CTL_RDMODE];
        cfg.share   <= wdata[CTL_SHARE];
      end
      if (wr && addr == ADDR_MODE) begin
        cfg.cpol <= wdata[0];
        cfg.cpha <= wdata[1];
      end
      if (start_wr) tx_hold <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_SPEED: begin
        rdata[DIV_W-1:0] = div;
        rdata[DIV_W]     = cfg.enable;
      end
      ADDR_CTRL: begin
        rdata[CTL_MASTER] = cfg.master;
        rdata[CTL_NODOUT] = cfg.no_dout;
        rdata[CTL_RDMODE] = cfg.rd_mode;
        rdata[CTL_SHARE]  = cfg.share;
        rdata[CTL_BUSY]   = busy;
      end
      ADDR_MODE: begin
        rdata[0] = cfg.cpol;
        rdata[1] = cfg.cpha;
      end
      default: rdata = rx_hold;
    endcase
  end
endmodule

// File: rtl/spirp_sckgen.sv
module spirp_sckgen #(
  parameter int DIV_W = 7,
  parameter int EDGES = 16,
  localparam int EW   = $clog2(EDGES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             active,
  input  logic [DIV_W-1:0] div,
  input  logic             cpol,
  output logic             tick,
  output logic [EW-1:0]    edge_idx,
  output logic             last_tick,
  output logic             sck
);
  logic [DIV_W-1:0] cnt;
  logic             sck_q;

  assign tick      = active && (cnt == div);
  assign last_tick = tick && (edge_idx == EW'(EDGES - 1));
  assign sck       = active ? sck_q : cpol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      edge_idx <= '0;
      sck_q    <= 1'b0;
    end else if (start) begin
      cnt      <= '0;
      edge_idx <= '0;
      sck_q    <= cpol;
    end else if (active) begin
      if (tick) begin
        cnt      <= '0;
        edge_idx <= edge_idx + 1'b1;
        sck_q    <= ~sck_q;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spirp_shift.sv
module spirp_shift
  import spirp_pkg::*;
#(
  parameter int DW = 8,
  parameter int EW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] tx_load,
  input  logic          tick,
  input  logic [EW-1:0] edge_idx,
  input  logic          last_tick,
  input  logic          cpha,
  input  logic          din,
  output logic          dout_bit,
  output logic [DW-1:0] rx_hold
);
  logic [DW-1:0] tx_sh, rx_sh, rx_next;
  logic          launch, sample;

  assign sample   = tick && is_sample_edge(edge_idx[0], cpha);
  assign launch   = tick && is_launch_edge(edge_idx[0], edge_idx == '0, cpha);
  assign rx_next  = sample ? {rx_sh[DW-2:0], din} : rx_sh;
  assign dout_bit = tx_sh[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_hold <= '0;
    end else if (start) begin
      tx_sh <= tx_load;
      rx_sh <= '0;
    end else begin
      if (launch) tx_sh <= {tx_sh[DW-2:0], 1'b0};
      rx_sh <= rx_next;
      if (last_tick) rx_hold <= rx_next;
    end
  end
endmodule

// File: rtl/spi_rdpipe_master.sv
module spi_rdpipe_master
  import spirp_pkg::*;
#(
  parameter int DIV_W = 7,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          spi_sck,
  output logic          spi_dout,
  output logic          spi_dout_en,
  input  logic          spi_din,
  input  logic          spi_dio_in
);
  localparam int EDGES = 2 * DW;
  localparam int EW    = $clog2(EDGES);

  cfg_t             cfg;
  logic [DIV_W-1:0] div_w;
  logic             start_evt, done_evt, busy_q, tick;
  logic [EW-1:0]    edge_idx;
  logic [DW-1:0]    tx_load, tx_hold, rx_hold;
  logic             dout_bit, din_sel;
  logic             cpol_w, share_w, no_dout_w, rd_mode_w;

  assign cpol_w    = cfg.cpol;
  assign share_w   = cfg.share;
  assign no_dout_w = cfg.no_dout;
  assign rd_mode_w = cfg.rd_mode;

  spirp_regs #(.DIV_W(DIV_W), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .busy(busy_q), .rx_hold(rx_hold), .rdata(bus_rdata),
    .cfg(cfg), .div(div_w), .start(start_evt), .tx_load(tx_load), .tx_hold(tx_hold)
  );

  spirp_sckgen #(.DIV_W(DIV_W), .EDGES(EDGES)) u_sck (
    .clk(clk), .rst_n(rst_n), .start(start_evt), .active(busy_q), .div(div_w),
    .cpol(cfg.cpol), .tick(tick), .edge_idx(edge_idx), .last_tick(done_evt), .sck(spi_sck)
  );

  spirp_shift #(.DW(DW), .EW(EW)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start_evt), .tx_load(tx_load), .tick(tick),
    .edge_idx(edge_idx), .last_tick(done_evt), .cpha(cfg.cpha), .din(din_sel),
    .dout_bit(dout_bit), .rx_hold(rx_hold)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy_q <= 1'b0;
    else if (start_evt) busy_q <= 1'b1;
    else if (done_evt)  busy_q <= 1'b0;
  end

  assign din_sel     = (cfg.share && cfg.no_dout) ? spi_dio_in : spi_din;
  assign spi_dout    = cfg.no_dout ? 1'b0 : dout_bit;
  assign spi_dout_en = !(cfg.share && cfg.no_dout);
endmodule

// File: rtl/spirp_chk.sv
module spirp_chk
  import spirp_pkg::*;
#(
  parameter int DIV_W = 7,
  parameter int DW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       bus_addr,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic             spi_sck,
  input logic             spi_dout,
  input logic             spi_dout_en,
  input logic             start_evt,
  input logic             done_evt,
  input logic             busy_q,
  input logic [DW-1:0]    tx_hold,
  input logic [DIV_W-1:0] div_w,
  input logic             cpol_w,
  input logic             share_w,
  input logic             no_dout_w,
  input logic             rd_mode_w
);
  logic [31:0] cyc_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cyc_cnt <= '0;
    else if (start_evt) cyc_cnt <= 32'd1;
    else if (busy_q)    cyc_cnt <= cyc_cnt + 32'd1;
  end

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy_q);

  // R2
  xfer_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> (cyc_cnt == xfer_cycles(32'(div_w), DW)));

  // R3
  sck_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (spi_sck == $past(cpol_w)));

  // R8
  busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && bus_wr && bus_addr == ADDR_DATA) |=> $stable(tx_hold));

  // R7
  no_rd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_DATA && !rd_mode_w && !busy_q && !bus_wr) |=> !busy_q);

  // R9
  dout_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && no_dout_w) |-> !spi_dout);

  // R10
  share_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && share_w && no_dout_w) |-> !spi_dout_en);
endmodule

bind spi_rdpipe_master spirp_chk #(.DIV_W(DIV_W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .spi_sck(spi_sck), .spi_dout(spi_dout), .spi_dout_en(spi_dout_en),
  .start_evt(start_evt), .done_evt(done_evt), .busy_q(busy_q), .tx_hold(tx_hold),
  .div_w(div_w), .cpol_w(cpol_w), .share_w(share_w), .no_dout_w(no_dout_w),
  .rd_mode_w(rd_mode_w)
);

// File: tb/tb_spi_rdpipe_master.sv
`timescale 1ns/1ps
module tb_spi_rdpipe_master;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic       bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata;
  logic       spi_sck, spi_dout, spi_dout_en, spi_din, spi_dio_in;

  always #10 clk = ~clk;

  spi_rdpipe_master dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck), .spi_dout(spi_dout),
    .spi_dout_en(spi_dout_en), .spi_din(spi_din), .spi_dio_in(spi_dio_in)
  );

  int vectors = 0, misses = 0;
  bit finished = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // slave model
  logic miso_bit = 1'b0;
  bit   inv_din = 0, inv_dio = 0;
  logic [7:0] s_tx, s_rx;
  int   s_edges, s_bp;
  bit   s_cpha;
  assign spi_din    = miso_bit ^ inv_din;
  assign spi_dio_in = miso_bit ^ inv_dio;

  task automatic arm(input logic [7:0] b, input bit cpha);
    s_tx = b; s_rx = '0; s_edges = 0; s_cpha = cpha;
    if (!cpha) begin miso_bit = b[7]; s_bp = 6; end
    else s_bp = 7;
  endtask

  always @(spi_sck) begin
    if ((s_edges % 2) == int'(s_cpha)) s_rx = {s_rx[6:0], spi_dout};
    else if (s_bp >= 0) begin miso_bit = s_tx[s_bp]; s_bp--; end
    s_edges++;
  end

  // scoreboard
  logic [7:0] exp_q[$];
  string      req_q[$];

  task automatic expect_rd(input logic [7:0] b, input string req);
    exp_q.push_back(b);
    req_q.push_back(req);
  endtask

  always @(negedge clk) begin
    #5;
    if (bus_rd && bus_addr == 2'd3) begin
      if (exp_q.size() == 0) check("R6 unexpected data read", 32'd1, 32'd0);
      else check(req_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #5 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    bus_addr = 2'd1; bus_rd = 1'b1;
    for (int g = 0; g < 5000; g++) begin
      #5;
      if (!bus_rdata[6]) break;
      cyc++;
      @(negedge clk);
    end
    bus_rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    misses++; vectors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [7:0] d, tx, sb;
    int cyc;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1;
    check("R1 sck", spi_sck, 0);
    check("R1 dout", spi_dout, 0);
    check("R1 dout_en", spi_dout_en, 1);
    rd(2'd1, d); check("R1 ctrl", d, 8'h00);
    rd(2'd0, d); check("R1 speed", d, 8'h00);

    // R11 no start without enable, then without master
    wr(2'd1, 8'h02); arm(8'h00, 0); wr(2'd3, 8'h55);
    rd(2'd1, d); check("R11 disabled", d, 8'h02);
    wr(2'd0, 8'h81); wr(2'd1, 8'h00); wr(2'd3, 8'h55);
    rd(2'd1, d); check("R11 no master", d, 8'h00);
    wr(2'd0, 8'h05); rd(2'd0, d); check("R11 speed replace", d, 8'h05);
    wr(2'd1, 8'h02); wr(2'd3, 8'h55);
    rd(2'd1, d); check("R11 enable cleared", d, 8'h02);

    // R2..R5 all four modes
    for (int m = 0; m < 4; m++) begin
      wr(2'd0, 8'h80 | 8'(m));
      wr(2'd2, 8'(m));
      #1 check("R3 idle level", spi_sck, m & 1);
      tx = 8'h96 ^ 8'(m * 37);
      sb = 8'hC3 ^ 8'(m * 91);
      arm(sb, m[1]);
      wr(2'd3, tx);
      wait_idle(cyc);
      check("R2 busy length", cyc, 16 * (m + 1));
      check("R4 slave got byte", s_rx, tx);
      check("R3 edge count", s_edges, 16);
      check("R3 end level", spi_sck, m & 1);
      expect_rd(sb, "R5 received byte");
      rd(2'd3, d);
      rd(2'd1, d); check("R7 read no start", d, 8'h02);
    end

    // R8 accesses while busy
    wr(2'd2, 8'h00); wr(2'd0, 8'h83);
    arm(8'h5A, 0);
    wr(2'd3, 8'hA1);
    wr(2'd3, 8'h3E);
    wait_idle(cyc);
    check("R8 length unchanged", cyc, 16 * 4 - 2);
    check("R8 first byte kept", s_rx, 8'hA1);

    // R6 read pipeline, output enabled
    wr(2'd1, 8'h0A);
    expect_rd(8'h5A, "R6 dummy read");
    arm(8'h77, 0);
    rd(2'd3, d);
    expect_rd(8'h5A, "R8 read while busy");
    rd(2'd3, d);
    wait_idle(cyc);
    check("R8 no restart", cyc, 16 * 4 - 2);
    check("R8 shifted held byte", s_rx, 8'hA1);
    expect_rd(8'h77, "R6 pipelined byte");
    arm(8'h19, 0);
    rd(2'd3, d);
    wait_idle(cyc);
    check("R6 launch length", cyc, 16 * 4);
    wr(2'd1, 8'h02);
    expect_rd(8'h19, "R7 final byte");
    rd(2'd3, d);
    rd(2'd1, d); check("R7 no launch", d, 8'h02);

    // R9 output disabled, R10 dedicated input without share
    wr(2'd1, 8'h0E);
    inv_dio = 1;
    arm(8'hE4, 0);
    expect_rd(8'h19, "R6 held byte");
    rd(2'd3, d);
    #1 check("R10 enable without share", spi_dout_en, 1);
    wait_idle(cyc);
    check("R9 output held low", s_rx, 8'h00);

    // R10 shared pin input
    wr(2'd1, 8'h2E);
    inv_dio = 0; inv_din = 1;
    arm(8'h6B, 0);
    expect_rd(8'hE4, "R10 dedicated pin byte");
    rd(2'd3, d);
    #1 check("R10 enable released", spi_dout_en, 0);
    wait_idle(cyc);
    wr(2'd1, 8'h26);
    expect_rd(8'h6B, "R10 shared pin byte");
    rd(2'd3, d);
    rd(2'd1, d); check("R10 ctrl readback", d, 8'h26);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule